// File: doc/BRIEF.md
# Thresholded Hue Histogram Accumulator

This block counts, for one rectangular window of an image, how many pixels fall into each of 36 hue bins that are 10 degrees wide. Pixels arrive one per cycle as a hue angle plus 5-bit saturation and intensity codes. A pixel is counted only if it lies inside the window and both its saturation and its intensity reach their thresholds. Each counted pixel adds one to the 12-bit counter of its hue bin.

A start pulse clears every counter in a single cycle and captures the window bounds and the two thresholds. A frame sync then sets the scan position to column 0, row 0. Each valid pixel moves one column to the right, and a line-end strobe moves to column 0 of the next row. When the pixel at the bottom-right corner of the window has been taken, the done flag rises. Software or a neighbouring block then reads the counts through an addressed port.

Top module: `hueHistogram`

## Requirements
- R1: After reset, done is 0 and every bin reads back 0.
- R2: A start pulse clears all 36 counters in one cycle and drops done in the following cycle. It also latches colLo, colHi, rowLo, rowHi, satThresh and intThresh, and the capture then waits for a frame sync.
- R3: A counted pixel whose 9-bit hue is 0 to 359 increments bin floor(hue/10).
- R4: A counted pixel whose hue is 360 or more increments bin 35.
- R5: A pixel is counted only if sat >= the latched satThresh (equal passes).
- R6: A pixel is counted only if inten >= the latched intThresh (equal passes).
- R7: Position rule. frameSync sets the position to (column 0, row 0). Each pixValid cycle uses the current position and then advances the column by one. lineEnd sets column 0 of the next row. A pixel is counted only if colLo <= column <= colHi and rowLo <= row <= rowHi. A pixValid in the same cycle as frameSync is ignored. The window may be anything from 1x1 to 128 columns by 64 rows.
- R8: Counters saturate at 4095 and never wrap.
- R9: done rises in the cycle after the valid pixel at position (colHi, rowHi) is taken, whether or not that pixel passed the gates. done stays high until the next start, and no pixel is counted while it is high.
- R10: rdData returns the count of bin rdAddr one cycle after rdAddr is presented. An address of 36 or above returns 0.
- R11: Valid pixels after a start but before the first frame sync are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| startPulse | input | 1 | Clears the counters and latches the window and thresholds |
| colLo | input | 7 | First column of the window (inclusive) |
| colHi | input | 7 | Last column of the window (inclusive) |
| rowLo | input | 6 | First row of the window (inclusive) |
| rowHi | input | 6 | Last row of the window (inclusive) |
| satThresh | input | 5 | Minimum saturation code for a pixel to be counted |
| intThresh | input | 5 | Minimum intensity code for a pixel to be counted |
| frameSync | input | 1 | Sets the scan position to column 0, row 0 |
| lineEnd | input | 1 | Moves the scan position to column 0 of the next row |
| pixValid | input | 1 | A pixel sample is present this cycle |
| hue | input | 9 | Hue angle in degrees |
| sat | input | 5 | Saturation code |
| inten | input | 5 | Intensity code |
| rdAddr | input | 6 | Bin index to read |
| rdData | output | 12 | Count of the bin addressed in the previous cycle |
| done | output | 1 | The window has been fully scanned |

## Verification
The bench sends hues at bin edges: 9, 10, 359, 360 and 511. A design with an off-by-one quotient or no clamp puts these pixels in the wrong bin, or in a bin that does not exist. Saturation and intensity are set exactly at their thresholds and one below them, so a strict comparison in place of >= leaves bin 1 short. The bench sends pixels before the frame sync, just outside every edge of the window and after done. A loose position or bounds check lets any of them into a count. It also fills one bin with 8192 pixels, so a counter that wraps reads back a small value in place of 4095. Finally it uses a 1x1 window away from the origin, which shows whether done follows the exact corner pixel.

// File: rtl/hueHistPkg.sv
package hueHistPkg;
  localparam int NUM_BINS = 36;
  localparam int BIN_DEG  = 10;
  localparam int HUE_W    = 9;
  localparam int CODE_W   = 5;
  localparam int CNT_W    = 12;
  localparam int COL_W    = 7;
  localparam int ROW_W    = 6;
  localparam int ADDR_W   = 6;

  typedef struct packed {
    logic clearAll;
    logic countEn;
  } histStrobes_t;

  typedef enum logic [1:0] {
    CAP_IDLE,
    CAP_ARMED,
    CAP_RUN,
    CAP_FIN
  } capState_t;
endpackage

// File: rtl/hueHistCtrl.sv
module hueHistCtrl
  import hueHistPkg::*;
#(
  parameter int COLS_W = COL_W,
  parameter int ROWS_W = ROW_W,
  parameter int GATE_W = CODE_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              startPulse,
  input  logic [COLS_W-1:0] colLo,
  input  logic [COLS_W-1:0] colHi,
  input  logic [ROWS_W-1:0] rowLo,
  input  logic [ROWS_W-1:0] rowHi,
  input  logic [GATE_W-1:0] satThresh,
  input  logic [GATE_W-1:0] intThresh,
  input  logic              frameSync,
  input  logic              lineEnd,
  input  logic              pixValid,
  input  logic [GATE_W-1:0] sat,
  input  logic [GATE_W-1:0] inten,
  output histStrobes_t      strobes,
  output logic              done
);
  // one spare bit so positions past the array edge never alias into the window
  localparam int CP_W = COLS_W + 1;
  localparam int RP_W = ROWS_W + 1;
  localparam logic [CP_W-1:0] COL_MAX = '1;
  localparam logic [RP_W-1:0] ROW_MAX = '1;

  capState_t         capState;
  logic [COLS_W-1:0] colLoQ, colHiQ;
  logic [ROWS_W-1:0] rowLoQ, rowHiQ;
  logic [GATE_W-1:0] satThQ, intThQ;
  logic [CP_W-1:0]   colPos;
  logic [RP_W-1:0]   rowPos;
  logic              doneQ;

  logic inWindow, atCorner, gatePass, takePix;

  always_comb begin
    inWindow = (colPos >= {1'b0, colLoQ}) && (colPos <= {1'b0, colHiQ}) &&
               (rowPos >= {1'b0, rowLoQ}) && (rowPos <= {1'b0, rowHiQ});
    atCorner = (colPos == {1'b0, colHiQ}) && (rowPos == {1'b0, rowHiQ});
    gatePass = (sat >= satThQ) && (inten >= intThQ);
    takePix  = !startPulse && !frameSync && pixValid && (capState == CAP_RUN);
    strobes.clearAll = startPulse;
    strobes.countEn  = takePix && inWindow && gatePass;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      capState <= CAP_IDLE;
      colLoQ   <= '0;
      colHiQ   <= '0;
      rowLoQ   <= '0;
      rowHiQ   <= '0;
      satThQ   <= '0;
      intThQ   <= '0;
      colPos   <= '0;
      rowPos   <= '0;
      doneQ    <= 1'b0;
    end else if (startPulse) begin
      capState <= CAP_ARMED;
      colLoQ   <= colLo;
      colHiQ   <= colHi;
      rowLoQ   <= rowLo;
      rowHiQ   <= rowHi;
      satThQ   <= satThresh;
      intThQ   <= intThresh;
      doneQ    <= 1'b0;
    end else if (frameSync && (capState == CAP_ARMED || capState == CAP_RUN)) begin
      capState <= CAP_RUN;
      colPos   <= '0;
      rowPos   <= '0;
    end else if (capState == CAP_RUN) begin
      if (takePix && atCorner) begin
        capState <= CAP_FIN;
        doneQ    <= 1'b1;
      end
      if (lineEnd) begin
        colPos <= '0;
        if (rowPos != ROW_MAX) rowPos <= rowPos + 1'b1;
      end else if (pixValid && colPos != COL_MAX) begin
        colPos <= colPos + 1'b1;
      end
    end
  end

  assign done = doneQ;
endmodule

// File: rtl/hueHistDatapath.sv
module hueHistDatapath
  import hueHistPkg::*;
#(
  parameter int BINS   = NUM_BINS,
  parameter int DEG    = BIN_DEG,
  parameter int ANG_W  = HUE_W,
  parameter int CW     = CNT_W,
  parameter int AW     = ADDR_W
) (
  input  logic             clk,
  input  logic             rstN,
  input  histStrobes_t     strobes,
  input  logic [ANG_W-1:0] hue,
  input  logic [AW-1:0]    rdAddr,
  output logic [CW-1:0]    rdData
);
  localparam logic [ANG_W-1:0] HUE_LIMIT = ANG_W'(BINS * DEG);
  localparam logic [ANG_W-1:0] DEG_V     = ANG_W'(DEG);
  localparam logic [AW-1:0]    LAST_BIN  = AW'(BINS - 1);
  localparam logic [AW-1:0]    BINS_V    = AW'(BINS);
  localparam logic [CW-1:0]    CNT_MAX   = '1;

  logic [ANG_W-1:0] hueQuot;
  logic [AW-1:0]    binIdx;
  logic [CW-1:0]    binCnt [BINS];
  logic [CW-1:0]    rdNext;

  always_comb begin
    hueQuot = hue / DEG_V;
    binIdx  = (hue >= HUE_LIMIT) ? LAST_BIN : AW'(hueQuot);
  end

  for (genvar b = 0; b < BINS; b++) begin : gBin
    always_ff @(posedge clk) begin
      if (!rstN || strobes.clearAll) begin
        binCnt[b] <= '0;
      end else if (strobes.countEn && binIdx == AW'(b) && binCnt[b] != CNT_MAX) begin
        binCnt[b] <= binCnt[b] + 1'b1;
      end
    end
  end

  always_comb begin
    rdNext = '0;
    if (rdAddr < BINS_V) rdNext = binCnt[rdAddr];
  end

  always_ff @(posedge clk) begin
    if (!rstN) rdData <= '0;
    else       rdData <= rdNext;
  end
endmodule

// File: rtl/hueHistogram.sv
module hueHistogram
  import hueHistPkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              startPulse,
  input  logic [COL_W-1:0]  colLo,
  input  logic [COL_W-1:0]  colHi,
  input  logic [ROW_W-1:0]  rowLo,
  input  logic [ROW_W-1:0]  rowHi,
  input  logic [CODE_W-1:0] satThresh,
  input  logic [CODE_W-1:0] intThresh,
  input  logic              frameSync,
  input  logic              lineEnd,
  input  logic              pixValid,
  input  logic [HUE_W-1:0]  hue,
  input  logic [CODE_W-1:0] sat,
  input  logic [CODE_W-1:0] inten,
  input  logic [ADDR_W-1:0] rdAddr,
  output logic [CNT_W-1:0]  rdData,
  output logic              done
);
  histStrobes_t strobes;

  hueHistCtrl #(.COLS_W(COL_W), .ROWS_W(ROW_W), .GATE_W(CODE_W)) ctrl (
    .clk(clk), .rstN(rstN), .startPulse(startPulse),
    .colLo(colLo), .colHi(colHi), .rowLo(rowLo), .rowHi(rowHi),
    .satThresh(satThresh), .intThresh(intThresh),
    .frameSync(frameSync), .lineEnd(lineEnd), .pixValid(pixValid),
    .sat(sat), .inten(inten), .strobes(strobes), .done(done)
  );

  hueHistDatapath #(.BINS(NUM_BINS), .DEG(BIN_DEG), .ANG_W(HUE_W),
                    .CW(CNT_W), .AW(ADDR_W)) dpath (
    .clk(clk), .rstN(rstN), .strobes(strobes), .hue(hue),
    .rdAddr(rdAddr), .rdData(rdData)
  );
endmodule

// File: rtl/hueHistogramChecker.sv
module hueHistogramChecker
  import hueHistPkg::*;
(
  input logic              clk,
  input logic              rstN,
  input logic              startPulse,
  input logic              pixValid,
  input logic              done,
  input logic [ADDR_W-1:0] rdAddr,
  input logic [CNT_W-1:0]  rdData,
  input logic              countEn
);
  // R2: done falls after a start
  a_r2_start_drops_done: assert property (@(posedge clk) disable iff (!rstN)
    startPulse |=> !done);

  // R9: done is held until the next start
  a_r9_done_sticky: assert property (@(posedge clk) disable iff (!rstN)
    (done && !startPulse) |=> done);

  // R9: done only rises after a pixel was taken
  a_r9_done_after_pixel: assert property (@(posedge clk) disable iff (!rstN)
    $rose(done) |-> $past(pixValid));

  // R9: nothing is counted once the window is complete
  a_r9_no_count_after_done: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !countEn);

  // R10: reads past the last bin return zero
  a_r10_oob_read_zero: assert property (@(posedge clk) disable iff (!rstN)
    (rdAddr >= ADDR_W'(NUM_BINS)) |=> (rdData == '0));
endmodule

bind hueHistogram hueHistogramChecker chk (
  .clk(clk), .rstN(rstN), .startPulse(startPulse), .pixValid(pixValid),
  .done(done), .rdAddr(rdAddr), .rdData(rdData), .countEn(strobes.countEn)
);

// File: tb/hueHistogram_test.sv
module hueHistogram_test;
  localparam int NB = 36;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic       rstN, startPulse, frameSync, lineEnd, pixValid;
  logic [6:0] colLo, colHi;
  logic [5:0] rowLo, rowHi;
  logic [4:0] satThresh, intThresh, sat, inten;
  logic [8:0] hue;
  logic [5:0] rdAddr;
  logic [11:0] rdData;
  logic       done;

  hueHistogram uut (
    .clk(clk), .rstN(rstN), .startPulse(startPulse),
    .colLo(colLo), .colHi(colHi), .rowLo(rowLo), .rowHi(rowHi),
    .satThresh(satThresh), .intThresh(intThresh),
    .frameSync(frameSync), .lineEnd(lineEnd), .pixValid(pixValid),
    .hue(hue), .sat(sat), .inten(inten),
    .rdAddr(rdAddr), .rdData(rdData), .done(done)
  );

  int checks = 0;
  int errors = 0;
  longint cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  // reference model state
  int expBins[NB];
  int mCl, mCh, mRl, mRh, mSt, mIt;
  int mState = 0;  // 0 idle, 1 armed, 2 run, 3 finished
  int mCol = 0, mRow = 0;

  typedef struct {
    int     addr;
    int     expVal;
    string  tag;
    longint due;
  } rdReq_t;
  rdReq_t rdQ[$];

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic finishRun();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  // monitor: compares read results one cycle after each address
  initial begin
    forever begin
      @(posedge clk);
      #2;
      while (rdQ.size() > 0 && rdQ[0].due <= cyc) begin
        rdReq_t r;
        r = rdQ.pop_front();
        check(rdData == 12'(r.expVal), r.tag, int'(rdData), r.expVal);
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finishRun();
  end

  task automatic readBin(input int a, input string tag);
    rdAddr = 6'(a);
    rdQ.push_back('{a, (a < NB) ? expBins[a] : 0, tag, cyc + 1});
    @(negedge clk);
  endtask

  task automatic readAll(input string tag);
    for (int a = 0; a < NB; a++) readBin(a, tag);
    repeat (2) @(negedge clk);
  endtask

  task automatic doStart(input int cl, input int ch, input int rl, input int rh,
                         input int st, input int it);
    colLo = 7'(cl); colHi = 7'(ch); rowLo = 6'(rl); rowHi = 6'(rh);
    satThresh = 5'(st); intThresh = 5'(it);
    startPulse = 1'b1;
    mCl = cl; mCh = ch; mRl = rl; mRh = rh; mSt = st; mIt = it;
    for (int b = 0; b < NB; b++) expBins[b] = 0;
    mState = 1;
    @(negedge clk);
    startPulse = 1'b0;
  endtask

  task automatic doFrame();
    frameSync = 1'b1;
    if (mState == 1 || mState == 2) begin
      mState = 2; mCol = 0; mRow = 0;
    end
    @(negedge clk);
    frameSync = 1'b0;
  endtask

  task automatic doLine();
    lineEnd = 1'b1;
    if (mState == 2) begin
      mRow++; mCol = 0;
    end
    @(negedge clk);
    lineEnd = 1'b0;
  endtask

  task automatic doPixel(input int h, input int s, input int i);
    hue = 9'(h); sat = 5'(s); inten = 5'(i);
    pixValid = 1'b1;
    if (mState == 2) begin
      if (mCol >= mCl && mCol <= mCh && mRow >= mRl && mRow <= mRh &&
          s >= mSt && i >= mIt) begin
        int b;
        b = (h >= 360) ? 35 : h / 10;
        if (expBins[b] < 4095) expBins[b]++;
      end
      if (mCol == mCh && mRow == mRh) mState = 3;
      mCol++;
    end
    @(negedge clk);
    pixValid = 1'b0;
  endtask

  initial begin
    rstN = 1'b0; startPulse = 1'b0; frameSync = 1'b0; lineEnd = 1'b0;
    pixValid = 1'b0; colLo = '0; colHi = '0; rowLo = '0; rowHi = '0;
    satThresh = '0; intThresh = '0; hue = '0; sat = '0; inten = '0; rdAddr = '0;
    for (int b = 0; b < NB; b++) expBins[b] = 0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1: reset state
    check(done == 1'b0, "R1 done after reset", int'(done), 0);
    readAll("R1 bins after reset");

    // window cols 2..6, rows 1..2, sat >= 10, inten >= 12
    doStart(2, 6, 1, 2, 10, 12);
    doPixel(100, 31, 31);               // R11: before frame sync
    doPixel(120, 31, 31);
    doFrame();
    for (int c = 0; c < 8; c++) doPixel(100, 31, 31);  // R7: row 0 outside
    doLine();
    doPixel(0, 31, 31);                 // R7: col 0 outside
    doPixel(0, 31, 31);                 // col 1 outside
    doPixel(0, 31, 31);                 // R3: bin 0
    doPixel(9, 31, 31);                 // R3: bin 0
    doPixel(10, 10, 12);                // R5 R6: exact thresholds, bin 1
    doPixel(359, 9, 31);                // R5: sat below
    doPixel(359, 31, 11);               // R6: intensity below
    doPixel(200, 31, 31);               // R7: col 7 outside
    doLine();
    doPixel(300, 31, 31);               // cols 0,1 outside
    doPixel(300, 31, 31);
    doPixel(360, 31, 31);               // R4: clamp to 35
    doPixel(511, 31, 31);               // R4
    doPixel(359, 31, 31);               // R3: bin 35
    check(done == 1'b0, "R9 done before corner", int'(done), 0);
    doPixel(185, 31, 31);               // col 5: bin 18
    check(done == 1'b0, "R9 done before corner", int'(done), 0);
    doPixel(65, 9, 31);                 // corner pixel, gated out
    check(done == 1'b1, "R9 done after corner", int'(done), 1);
    doPixel(185, 31, 31);               // R9: after done, ignored
    repeat (3) @(negedge clk);
    check(done == 1'b1, "R9 done sticky", int'(done), 1);
    readAll("R3 R4 R5 R6 R7 R9 R11 mapping and gating");

    // R2: start clears all bins and done
    doStart(0, 127, 0, 63, 0, 0);
    check(done == 1'b0, "R2 done after start", int'(done), 0);
    readAll("R2 bins after start");

    // R8: full 128x64 window into one bin
    doFrame();
    for (int r = 0; r < 64; r++) begin
      for (int c = 0; c < 128; c++) doPixel(50, 0, 0);
      if (r < 63) doLine();
    end
    check(done == 1'b1, "R9 done after full window", int'(done), 1);
    readBin(5, "R8 saturated bin");
    readBin(4, "R8 neighbour bin");
    readBin(6, "R8 neighbour bin");
    repeat (2) @(negedge clk);

    // R7: 1x1 window at col 5 row 3
    doStart(5, 5, 3, 3, 31, 31);
    doFrame();
    for (int c = 0; c < 8; c++) doPixel(30, 31, 31);   // row 0
    doLine();
    doLine();
    doLine();
    for (int c = 0; c < 5; c++) doPixel(120, 31, 31);
    check(done == 1'b0, "R9 done before 1x1 pixel", int'(done), 0);
    doPixel(275, 31, 31);
    check(done == 1'b1, "R9 done after 1x1 pixel", int'(done), 1);
    readAll("R7 R3 1x1 window");

    // R10: out of range addresses
    readBin(36, "R10 address 36");
    readBin(63, "R10 address 63");
    readBin(27, "R10 in-range after out-of-range");
    repeat (3) @(negedge clk);

    finishRun();
  end
endmodule